// File: doc/BRIEF.md
# Descriptor Ring Copy Channel

This block is one copy channel. Two circular descriptor rings live in a small local descriptor store: a source ring that lists buffers to send, and a destination ring that lists empty buffers waiting for data. Software fills descriptors and then advances a write index. The engine walks the source ring from its current read index and copies each buffer byte by byte into the current destination buffer. It then writes the received byte count back into the destination descriptor and publishes its progress by advancing the hardware read indices.

Source descriptors with the gather flag set are packed back to back into one destination buffer. The first source descriptor without the flag closes the run and produces a single completion. A destination descriptor whose count field reads zero has not been filled yet. The bytes taken from one source descriptor are capped by a programmable maximum length. Byte order inside each 32-bit word can be reversed per descriptor or per ring side. A ring whose size register holds zero is disabled.

Descriptor store, byte store and registers all sit behind one simple word-wide configuration bus. A testbench or a host model uses that bus to preload buffers, post descriptors, move indices and read back results.

Top module: `ring_copy_engine`

## Requirements
- R1: After reset the source and destination read indices read 0, and the control register reads 0x0000FFFF (maximum length 0xFFFF, both swap enables clear).
- R2: A source descriptor (word 0 = byte address, word 1 = count in bits 15:0 and flags in bits 31:16) is copied byte for byte to the address held in word 0 of the destination descriptor at the destination read index. Both read indices then advance by one.
- R3: On completion, word 1 of the destination descriptor becomes {transfer id of the last source descriptor of the run in bits 31:20, zero in bits 19:16, total byte count in bits 15:0}. The transfer id is source flag bits 15:4. Flag bit 0 is gather and flag bit 1 is swap.
- R4: Consecutive source descriptors with the gather bit set, plus the first one after them without it, fill one destination buffer contiguously. Together they give exactly one completion and one destination read index advance.
- R5: Every read index wraps modulo the ring size (a power of two). The write index is compared after masking with size minus one.
- R6: No source descriptor is started while no destination buffer is posted (destination read index equal to the masked destination write index). The source read index holds until one is posted, and the copy then completes normally.
- R7: The bytes taken from one source descriptor are min(count, maxLen), where maxLen is control bits 15:0. Destination bytes beyond that are left untouched.
- R8: A source descriptor with flag bit 1 set has the byte order reversed inside each 32-bit word of its data. Lengths are multiples of 4 when any swap applies.
- R9: Control bit 16 reverses source bytes for every descriptor, and control bit 17 reverses the byte order on the destination side. When both sides reverse, the data arrives unchanged.
- R10: A source or destination ring size of zero blocks all transfers. Posted work starts once the size is made nonzero again.
- R11: The destination read index advances only in the cycle after the count write-back, so a reader that sees the new index also sees a nonzero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | CFG_AW (8) | Word address; bits 7:6 select registers (0), descriptor store (1) or byte store (2) |
| cfgWdata | input | 32 | Write data |
| cfgRdata | output | 32 | Combinational read data |

Register word offsets: 0 source base entry, 1 source size, 2 source write index, 3 source read index (read only), 4 destination base entry, 5 destination size, 6 destination write index, 7 destination read index (read only), 8 control. In the descriptor region, address bits 5:1 give the entry and bit 0 the word. In the byte region, bits 5:0 give the word, and the bytes within it are stored little-endian.

## Verification
The copy path is driven with a plain single-descriptor transfer, a three-descriptor gather run that also wraps the source ring, a transfer whose length exceeds the cap, and transfers under each swap source. Each of these gives a different expected pattern in the destination bytes and in the written-back count word. The pattern shows whether bytes were merged, cut short or reordered, and whether the id came from the last descriptor of the run. Two stall cases post source work with no destination buffer available, and with a ring disabled by a zero size. In each, the indices must stay frozen until the condition clears.

// File: rtl/rce_pkg.sv
package rce_pkg;
  typedef struct packed {
    logic ldSrc;
    logic ldDst;
    logic copy;
    logic srcAdv;
    logic wb;
    logic dstAdv;
  } rceStrobe_t;

  typedef struct packed {
    logic srcAvail;
    logic dstAvail;
    logic remainZero;
    logic curGather;
  } rceStatus_t;

  typedef enum logic [1:0] {ST_IDLE, ST_COPY, ST_WB, ST_ADV} rceState_t;

  localparam int FLAG_GATHER = 0;
  localparam int FLAG_SWAP   = 1;
  localparam int ID_LSB      = 4;

  localparam logic [3:0] REG_SRC_BASE = 4'd0;
  localparam logic [3:0] REG_SRC_SIZE = 4'd1;
  localparam logic [3:0] REG_SRC_WR   = 4'd2;
  localparam logic [3:0] REG_SRC_RD   = 4'd3;
  localparam logic [3:0] REG_DST_BASE = 4'd4;
  localparam logic [3:0] REG_DST_SIZE = 4'd5;
  localparam logic [3:0] REG_DST_WR   = 4'd6;
  localparam logic [3:0] REG_DST_RD   = 4'd7;
  localparam logic [3:0] REG_CTRL     = 4'd8;
endpackage

// File: rtl/rce_ctrl.sv
module rce_ctrl
  import rce_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  rceStatus_t stat,
  output rceStrobe_t strb
);
  rceState_t state, stateNext;
  logic inRun, inRunNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    inRunNext = inRun;
    unique case (state)
      ST_IDLE: begin
        if (stat.srcAvail && (inRun || stat.dstAvail)) begin
          strb.ldSrc = 1'b1;
          strb.ldDst = !inRun;
          stateNext  = ST_COPY;
        end
      end
      ST_COPY: begin
        if (!stat.remainZero) begin
          strb.copy = 1'b1;
        end else begin
          strb.srcAdv = 1'b1;
          if (stat.curGather) begin
            inRunNext = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            stateNext = ST_WB;
          end
        end
      end
      ST_WB: begin
        strb.wb   = 1'b1;
        stateNext = ST_ADV;
      end
      ST_ADV: begin
        strb.dstAdv = 1'b1;
        inRunNext   = 1'b0;
        stateNext   = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      inRun <= 1'b0;
    end else begin
      state <= stateNext;
      inRun <= inRunNext;
    end
  end
endmodule

// File: rtl/rce_dp.sv
module rce_dp
  import rce_pkg::*;
#(
  parameter int DESC_DEPTH = 32,
  parameter int DATA_BYTES = 256,
  parameter int CFG_AW     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [31:0]       cfgWdata,
  output logic [31:0]       cfgRdata,
  input  rceStrobe_t        strb,
  output rceStatus_t        stat,
  output logic [$clog2(DESC_DEPTH)-1:0] dstRdIdx
);
  localparam int DESC_AW = $clog2(DESC_DEPTH);
  localparam int DATA_AW = $clog2(DATA_BYTES);
  localparam int IDX_W   = DESC_AW;
  localparam int WORDS   = DATA_BYTES / 4;
  localparam int WORD_AW = DATA_AW - 2;

  logic [31:0] descAddr [DESC_DEPTH];
  logic [31:0] descCtl  [DESC_DEPTH];
  logic [7:0]  dataMem  [DATA_BYTES];

  logic [DESC_AW-1:0] srcBase, dstBase;
  logic [IDX_W:0]     srcSize, dstSize;
  logic [IDX_W-1:0]   srcWr, dstWr, srcRd, dstRd;
  logic [15:0]        maxLen;
  logic               srcSwapEn, dstSwapEn;

  logic [DATA_AW-1:0] curSrc, curDst;
  logic [15:0]        remain, srcOff, dstOff, curFlags;
  logic               sSwap;

  logic [1:0]         region;
  logic [3:0]         regSel;
  logic [DESC_AW-1:0] busEnt;
  logic [WORD_AW-1:0] busWord;
  logic [IDX_W-1:0]   srcMask, dstMask;
  logic [DESC_AW-1:0] srcEnt, dstEnt;
  logic [DATA_AW-1:0] rdByte, wrByte;
  logic [15:0]        srcCount, takeLen;
  logic [15:0]        srcFlags;

  assign region  = cfgAddr[CFG_AW-1 -: 2];
  assign regSel  = cfgAddr[3:0];
  assign busEnt  = cfgAddr[DESC_AW:1];
  assign busWord = cfgAddr[WORD_AW-1:0];

  assign srcMask = IDX_W'(srcSize - 1'b1);
  assign dstMask = IDX_W'(dstSize - 1'b1);
  assign srcEnt  = srcBase + DESC_AW'(srcRd);
  assign dstEnt  = dstBase + DESC_AW'(dstRd);

  assign srcCount = descCtl[srcEnt][15:0];
  assign srcFlags = descCtl[srcEnt][31:16];
  assign takeLen  = (srcCount > maxLen) ? maxLen : srcCount;

  assign rdByte = curSrc + DATA_AW'(srcOff ^ {14'd0, sSwap, sSwap});
  assign wrByte = curDst + DATA_AW'(dstOff ^ {14'd0, dstSwapEn, dstSwapEn});

  assign stat.srcAvail   = (srcSize != '0) && (dstSize != '0) &&
                           (srcRd != (srcWr & srcMask));
  assign stat.dstAvail   = (dstRd != (dstWr & dstMask));
  assign stat.remainZero = (remain == 16'd0);
  assign stat.curGather  = curFlags[FLAG_GATHER];
  assign dstRdIdx        = dstRd;

  // Registers written by software and indices advanced by the engine.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcBase   <= '0;
      dstBase   <= '0;
      srcSize   <= '0;
      dstSize   <= '0;
      srcWr     <= '0;
      dstWr     <= '0;
      srcRd     <= '0;
      dstRd     <= '0;
      maxLen    <= 16'hFFFF;
      srcSwapEn <= 1'b0;
      dstSwapEn <= 1'b0;
    end else begin
      if (strb.srcAdv) srcRd <= (srcRd + 1'b1) & srcMask;
      if (strb.dstAdv) dstRd <= (dstRd + 1'b1) & dstMask;
      if (cfgWe && region == 2'd0) begin
        unique case (regSel)
          REG_SRC_BASE: srcBase <= cfgWdata[DESC_AW-1:0];
          REG_SRC_SIZE: srcSize <= cfgWdata[IDX_W:0];
          REG_SRC_WR:   srcWr   <= cfgWdata[IDX_W-1:0];
          REG_DST_BASE: dstBase <= cfgWdata[DESC_AW-1:0];
          REG_DST_SIZE: dstSize <= cfgWdata[IDX_W:0];
          REG_DST_WR:   dstWr   <= cfgWdata[IDX_W-1:0];
          REG_CTRL: begin
            maxLen    <= cfgWdata[15:0];
            srcSwapEn <= cfgWdata[16];
            dstSwapEn <= cfgWdata[17];
          end
          default: ;
        endcase
      end
    end
  end

  // Per-transfer working state.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSrc   <= '0;
      curDst   <= '0;
      remain   <= '0;
      srcOff   <= '0;
      dstOff   <= '0;
      curFlags <= '0;
      sSwap    <= 1'b0;
    end else begin
      if (strb.ldDst) begin
        curDst <= descAddr[dstEnt][DATA_AW-1:0];
        dstOff <= '0;
      end
      if (strb.ldSrc) begin
        curSrc   <= descAddr[srcEnt][DATA_AW-1:0];
        remain   <= takeLen;
        srcOff   <= '0;
        curFlags <= srcFlags;
        sSwap    <= srcFlags[FLAG_SWAP] | srcSwapEn;
      end
      if (strb.copy) begin
        remain <= remain - 1'b1;
        srcOff <= srcOff + 1'b1;
        dstOff <= dstOff + 1'b1;
      end
    end
  end

  // Storage: engine writes first, a same-cycle bus write takes precedence.
  always_ff @(posedge clk) begin
    if (strb.copy) dataMem[wrByte] <= dataMem[rdByte];
    if (strb.wb)   descCtl[dstEnt] <= {curFlags[15:ID_LSB], 4'd0, dstOff};
    if (cfgWe && region == 2'd1) begin
      if (cfgAddr[0]) descCtl[busEnt]  <= cfgWdata;
      else            descAddr[busEnt] <= cfgWdata;
    end
    if (cfgWe && region == 2'd2) begin
      for (int b = 0; b < 4; b++)
        dataMem[{busWord, 2'(b)}] <= cfgWdata[8*b +: 8];
    end
  end

  always_comb begin
    cfgRdata = '0;
    unique case (region)
      2'd0: begin
        unique case (regSel)
          REG_SRC_BASE: cfgRdata = 32'(srcBase);
          REG_SRC_SIZE: cfgRdata = 32'(srcSize);
          REG_SRC_WR:   cfgRdata = 32'(srcWr);
          REG_SRC_RD:   cfgRdata = 32'(srcRd);
          REG_DST_BASE: cfgRdata = 32'(dstBase);
          REG_DST_SIZE: cfgRdata = 32'(dstSize);
          REG_DST_WR:   cfgRdata = 32'(dstWr);
          REG_DST_RD:   cfgRdata = 32'(dstRd);
          REG_CTRL:     cfgRdata = {14'd0, dstSwapEn, srcSwapEn, maxLen};
          default:      cfgRdata = '0;
        endcase
      end
      2'd1: cfgRdata = cfgAddr[0] ? descCtl[busEnt] : descAddr[busEnt];
      2'd2: cfgRdata = {dataMem[{busWord, 2'd3}], dataMem[{busWord, 2'd2}],
                        dataMem[{busWord, 2'd1}], dataMem[{busWord, 2'd0}]};
      default: cfgRdata = '0;
    endcase
  end

  if (WORDS * 4 != DATA_BYTES) begin : g_bad_size
    initial $error("DATA_BYTES must be a multiple of 4");
  end
endmodule

// File: rtl/ring_copy_engine.sv
module ring_copy_engine
  import rce_pkg::*;
#(
  parameter int DESC_DEPTH = 32,
  parameter int DATA_BYTES = 256,
  localparam int DESC_AW = $clog2(DESC_DEPTH),
  localparam int DATA_AW = $clog2(DATA_BYTES),
  localparam int LOC_W   = (DESC_AW + 1 > DATA_AW - 2) ? DESC_AW + 1 : DATA_AW - 2,
  localparam int CFG_AW  = LOC_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [31:0]       cfgWdata,
  output logic [31:0]       cfgRdata
);
  rceStrobe_t         strb;
  rceStatus_t         stat;
  logic [DESC_AW-1:0] dstRdIdx;

  rce_ctrl ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .stat (stat),
    .strb (strb)
  );

  rce_dp #(
    .DESC_DEPTH (DESC_DEPTH),
    .DATA_BYTES (DATA_BYTES),
    .CFG_AW     (CFG_AW)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgWdata (cfgWdata),
    .cfgRdata (cfgRdata),
    .strb     (strb),
    .stat     (stat),
    .dstRdIdx (dstRdIdx)
  );
endmodule

// File: rtl/rce_chk.sv
module rce_chk
  import rce_pkg::*;
#(
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rstN,
  input rceStrobe_t    strb,
  input rceStatus_t    stat,
  input logic [IW-1:0] dstRdIdx
);
  a_r11_adv_after_wb: assert property (@(posedge clk) disable iff (!rstN)
    strb.dstAdv |-> $past(strb.wb));

  a_r11_idx_moves_on_adv: assert property (@(posedge clk) disable iff (!rstN)
    (dstRdIdx != $past(dstRdIdx)) |-> $past(strb.dstAdv));

  a_r6_dst_present: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldDst |-> stat.dstAvail);

  a_r10_src_enabled: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldSrc |-> stat.srcAvail);

  a_r7_copy_in_budget: assert property (@(posedge clk) disable iff (!rstN)
    strb.copy |-> !stat.remainZero);

  a_r4_adv_when_drained: assert property (@(posedge clk) disable iff (!rstN)
    strb.srcAdv |-> stat.remainZero);

  a_r2_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ldSrc, strb.copy, strb.srcAdv, strb.wb, strb.dstAdv}));
endmodule

bind ring_copy_engine rce_chk #(.IW(DESC_AW)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .strb     (strb),
  .stat     (stat),
  .dstRdIdx (dstRdIdx)
);

// File: tb/ring_copy_engine_tb_top.sv
module ring_copy_engine_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ring_copy_engine dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgWdata (cfgWdata),
    .cfgRdata (cfgRdata)
  );

  function automatic logic [7:0] regA(input int i);
    return 8'(i);
  endfunction
  function automatic logic [7:0] descA(input int ent, input int w);
    return {2'b01, 5'(ent), 1'(w)};
  endfunction
  function automatic logic [7:0] dataA(input int byteAddr);
    return {2'b10, 6'(byteAddr >> 2)};
  endfunction
  function automatic logic [31:0] pat(input int byteAddr);
    return {8'(byteAddr + 3), 8'(byteAddr + 2), 8'(byteAddr + 1), 8'(byteAddr)};
  endfunction
  function automatic logic [31:0] swp(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfgAddr = a;
    #1 d = cfgRdata;
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expectRd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    check(v == exp, tag, v, exp);
  endtask

  task automatic waitDst(input int target, input string tag);
    logic [31:0] v = '0;
    for (int i = 0; i < 2000; i++) begin
      rd(regA(7), v);
      if (v == 32'(target)) break;
    end
    check(v == 32'(target), tag, v, 32'(target));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    expectRd(regA(3), 32'd0, "R1 src read index after reset");
    expectRd(regA(7), 32'd0, "R1 dst read index after reset");
    expectRd(regA(8), 32'h0000FFFF, "R1 control after reset");
  endtask

  task automatic t_single;
    wr(descA(0, 0), 32'd0);
    wr(descA(0, 1), 32'h0050_0008);
    wr(descA(8, 0), 32'd128);
    wr(descA(8, 1), 32'd0);
    wr(regA(6), 32'd1);
    wr(regA(2), 32'd1);
    waitDst(1, "R2 dst read index after single copy");
    expectRd(descA(8, 1), 32'h0050_0008, "R11 R3 count and id written back");
    expectRd(dataA(128), pat(0), "R2 data word 0");
    expectRd(dataA(132), pat(4), "R2 data word 1");
    expectRd(regA(3), 32'd1, "R2 src read index advanced");
  endtask

  task automatic t_gather;
    wr(descA(1, 0), 32'd16); wr(descA(1, 1), 32'h0011_0004);
    wr(descA(2, 0), 32'd20); wr(descA(2, 1), 32'h0001_0008);
    wr(descA(3, 0), 32'd28); wr(descA(3, 1), 32'h0090_0004);
    wr(descA(9, 0), 32'd144); wr(descA(9, 1), 32'd0);
    wr(regA(6), 32'd2);
    wr(regA(2), 32'd4);
    waitDst(2, "R4 one dst advance for gather run");
    expectRd(descA(9, 1), 32'h0090_0010, "R4 R3 merged count, last id");
    for (int w = 0; w < 4; w++)
      expectRd(dataA(144 + 4 * w), pat(16 + 4 * w), "R4 merged data");
    expectRd(regA(3), 32'd0, "R5 src read index wrapped to 0");
  endtask

  task automatic t_stall;
    wr(descA(0, 0), 32'd32); wr(descA(0, 1), 32'h0020_0004);
    wr(descA(10, 0), 32'd160); wr(descA(10, 1), 32'd0);
    wr(regA(2), 32'd5);
    idle(50);
    expectRd(regA(3), 32'd0, "R6 src held without dst buffer");
    expectRd(regA(7), 32'd2, "R6 dst index held");
    wr(regA(6), 32'd3);
    waitDst(3, "R6 copy after dst posted");
    expectRd(dataA(160), pat(32), "R6 data after stall");
    expectRd(regA(3), 32'd1, "R6 src advanced after stall");
  endtask

  task automatic t_maxlen;
    wr(regA(8), 32'h0000_0004);
    wr(descA(1, 0), 32'd40); wr(descA(1, 1), 32'h0030_000C);
    wr(descA(11, 0), 32'd176); wr(descA(11, 1), 32'd0);
    wr(regA(6), 32'd4);
    wr(regA(2), 32'd6);
    waitDst(0, "R7 R5 dst index wraps after capped copy");
    expectRd(descA(11, 1), 32'h0030_0004, "R7 count capped");
    expectRd(dataA(176), pat(40), "R7 first word copied");
    expectRd(dataA(180), 32'd0, "R7 bytes past cap untouched");
    wr(regA(8), 32'h0000_FFFF);
  endtask

  task automatic t_swapflag;
    wr(descA(2, 0), 32'd48); wr(descA(2, 1), 32'h0042_0008);
    wr(descA(8, 0), 32'd192); wr(descA(8, 1), 32'd0);
    wr(regA(6), 32'd5);
    wr(regA(2), 32'd7);
    waitDst(1, "R8 swap-flag copy completes");
    expectRd(dataA(192), swp(pat(48)), "R8 word 0 reversed");
    expectRd(dataA(196), swp(pat(52)), "R8 word 1 reversed");
    expectRd(descA(8, 1), 32'h0040_0008, "R3 flag bits cleared in write-back");
  endtask

  task automatic t_swapcfg;
    wr(regA(8), 32'h0002_FFFF);
    wr(descA(3, 0), 32'd56); wr(descA(3, 1), 32'h0060_0004);
    wr(descA(9, 0), 32'd200); wr(descA(9, 1), 32'd0);
    wr(regA(6), 32'd6);
    wr(regA(2), 32'd8);
    waitDst(2, "R9 dst-side swap copy completes");
    expectRd(dataA(200), swp(pat(56)), "R9 dst-side swap reverses");
    wr(regA(8), 32'h0003_FFFF);
    wr(descA(0, 0), 32'd60); wr(descA(0, 1), 32'h0060_0004);
    wr(descA(10, 0), 32'd204); wr(descA(10, 1), 32'd0);
    wr(regA(6), 32'd7);
    wr(regA(2), 32'd9);
    waitDst(3, "R9 double swap copy completes");
    expectRd(dataA(204), pat(60), "R9 both swaps cancel");
    wr(regA(8), 32'h0000_FFFF);
  endtask

  task automatic t_disable;
    wr(regA(1), 32'd0);
    wr(descA(1, 0), 32'd64); wr(descA(1, 1), 32'h0070_0004);
    wr(descA(11, 0), 32'd208); wr(descA(11, 1), 32'd0);
    wr(regA(6), 32'd8);
    wr(regA(2), 32'd10);
    idle(40);
    expectRd(regA(7), 32'd3, "R10 no completion while disabled");
    expectRd(descA(11, 1), 32'd0, "R10 dst descriptor untouched");
    wr(regA(1), 32'd4);
    waitDst(0, "R10 resumes after size restored");
    expectRd(dataA(208), pat(64), "R10 data after enable");
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    t_reset;
    for (int a = 0; a < 128; a += 4) wr(dataA(a), pat(a));
    for (int a = 128; a < 256; a += 4) wr(dataA(a), 32'd0);
    wr(regA(0), 32'd0);
    wr(regA(1), 32'd4);
    wr(regA(4), 32'd8);
    wr(regA(5), 32'd4);
    t_single;
    t_gather;
    t_stall;
    t_maxlen;
    t_swapflag;
    t_swapcfg;
    t_disable;
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule